// File: doc/BRIEF.md
# Channel Context Command Engine

This engine serves the control channel of a multi-channel DMA core. A host hands it one buffer descriptor at a time: an 8-bit command, a 16-bit count, a status byte, a host buffer address and an internal start address. The command picks one of three kinds of work. It can save or restore a 32-word channel context. It can move 32-bit words between the host buffer and the internal data memory. It can move 16-bit halfwords between the same two places. The engine then streams the data one beat per cycle, through a valid/ready port toward the host buffer and a single-cycle port into the internal RAM.

For the two context commands, the channel number sits in the upper five command bits. The internal address is a fixed base plus a stride of 32 words per channel. When the engine finishes, it raises a one-cycle done pulse. It also returns the descriptor status with the ownership bit cleared and the error bit set or cleared. A fault signalled on the host port ends the command early. The same error path also handles any command code the engine does not recognise.

Top module: `ctx_cmd_engine`

## Requirements
- R1: A command with bits [2:0] = 3'b111 performs a context restore for channel c = cmd[7:3]. It reads 32 host words from buf_addr + 4*i and writes each one to internal word 0x800 + 32*c + i, for i = 0..31. The count field and the internal start address are ignored.
- R2: A command with bits [2:0] = 3'b011 performs a context save. It reads internal words 0x800 + 32*c + i and writes them to host address buf_addr + 4*i, for i = 0..31.
- R3: Command 0x01 copies count host words at buf_addr + 4*i to internal words ext_addr + i, with mem_be_o = 2'b11.
- R4: Command 0x02 copies count internal words at ext_addr + i to host address buf_addr + 4*i.
- R5: Command 0x04 writes the low 16 bits of host word i to internal halfword h = ext_addr + i. That halfword is word h>>1, in the upper half when h[0] = 1 and the lower half otherwise. Only that half is enabled: mem_be_o bit 1 enables the upper half and bit 0 the lower half.
- R6: Command 0x08 reads internal halfword h = ext_addr + i, zero-extends it, and writes it to host address buf_addr + 4*i.
- R7: A word or halfword command with count 0 completes with no memory or host access and no error.
- R8: Any other command code completes with the error bit set and touches neither memory.
- R9: If hreq_err_i is high on an accepted beat, the command ends on that beat. That beat writes neither memory, and the error bit is set.
- R10: When done_o is high, status_o equals the descriptor status with bit 0 (owned) cleared and bit 4 (error) set exactly when the command failed.
- R11: Each beat holds hreq_valid_o and a stable hreq_addr_o until hreq_ready_i. The engine completes at most one beat per cycle, and exactly the number of beats the command requires.
- R12: A start_i pulse while busy_o is high is ignored.
- R13: done_o is a one-cycle pulse. It comes in the cycle after the final beat, or in the cycle after start for R7 and R8, and busy_o is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept descriptor while idle |
| cmd_i | input | 8 | Descriptor command |
| count_i | input | 16 | Descriptor count |
| status_i | input | 8 | Descriptor status byte |
| buf_addr_i | input | 32 | Host buffer byte address |
| ext_addr_i | input | 14 | Internal word or halfword start address |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| status_o | output | 8 | Updated descriptor status |
| hreq_valid_o | output | 1 | Host beat request |
| hreq_ready_i | input | 1 | Host beat accepted |
| hreq_we_o | output | 1 | Host write (1) or read (0) |
| hreq_addr_o | output | 32 | Host byte address |
| hreq_wdata_o | output | 32 | Host write data |
| hrsp_rdata_i | input | 32 | Host read data, valid with ready |
| hreq_err_i | input | 1 | Host fault, valid with ready |
| mem_we_o | output | 1 | Internal write strobe |
| mem_re_o | output | 1 | Internal read enable |
| mem_addr_o | output | 14 | Internal word address |
| mem_be_o | output | 2 | Halfword enables |
| mem_wdata_o | output | 32 | Internal write data |
| mem_rdata_i | input | 32 | Internal read data, same cycle |

## Verification
Two things can land on the same clock edge: the final beat of a transfer and a host fault. The bench drives the fault on beat count-1, and also on beat 31 of a context command. It then checks that the faulted word was left unwritten while every earlier beat landed. The done pulse must still arrive on the next cycle, with the error bit set. A second collision is a start_i pulse carrying an illegal code, issued mid-transfer. That pulse must leave both memories and the status exactly as the running command alone would.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [2:0] {
    OP_BAD, OP_CTX_WR, OP_CTX_RD, OP_W_WR, OP_W_RD, OP_H_WR, OP_H_RD
  } op_e;

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  localparam logic [7:0] STAT_OWN = 8'h01;
  localparam logic [7:0] STAT_ERR = 8'h10;

  function automatic op_e decode_op(input logic [7:0] cmd);
    if (cmd[2:0] == 3'b111) return OP_CTX_WR;
    if (cmd[2:0] == 3'b011) return OP_CTX_RD;
    case (cmd)
      8'h01:   return OP_W_WR;
      8'h02:   return OP_W_RD;
      8'h04:   return OP_H_WR;
      8'h08:   return OP_H_RD;
      default: return OP_BAD;
    endcase
  endfunction
endpackage

// File: rtl/ctx_decode.sv
module ctx_decode import ctx_pkg::*; #(
  parameter int CNT_W     = 16,
  parameter int CH_W      = 5,
  parameter int CTX_WORDS = 32
) (
  input  logic [7:0]       cmd_i,
  input  logic [CNT_W-1:0] count_i,
  output op_e              op_o,
  output logic             to_mem_o,
  output logic             half_o,
  output logic             ctx_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [CNT_W-1:0] beats_o
);
  always_comb begin
    op_o     = decode_op(cmd_i);
    ctx_o    = (op_o == OP_CTX_WR) || (op_o == OP_CTX_RD);
    half_o   = (op_o == OP_H_WR) || (op_o == OP_H_RD);
    to_mem_o = (op_o == OP_CTX_WR) || (op_o == OP_W_WR) || (op_o == OP_H_WR);
    ch_o     = CH_W'(cmd_i[7:3]);
    if (op_o == OP_BAD) beats_o = '0;
    else if (ctx_o)     beats_o = CNT_W'(CTX_WORDS);
    else                beats_o = count_i;
  end
endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen #(
  parameter int              HOST_AW   = 32,
  parameter int              MEM_AW    = 14,
  parameter int              CNT_W     = 16,
  parameter int              CH_W      = 5,
  parameter logic [MEM_AW-1:0] CTX_BASE = 14'h800,
  parameter int              CTX_WORDS = 32
) (
  input  logic               ctx_i,
  input  logic               half_i,
  input  logic [CH_W-1:0]    ch_i,
  input  logic [MEM_AW-1:0]  ext_i,
  input  logic [HOST_AW-1:0] buf_i,
  input  logic [CNT_W-1:0]   idx_i,
  output logic [MEM_AW-1:0]  mem_addr_o,
  output logic               lane_o,
  output logic [HOST_AW-1:0] host_addr_o
);
  localparam int CTX_SH = $clog2(CTX_WORDS);

  logic [MEM_AW-1:0] ctx_word, lin;

  always_comb begin
    ctx_word    = CTX_BASE + (MEM_AW'(ch_i) << CTX_SH) + MEM_AW'(idx_i);
    lin         = ext_i + MEM_AW'(idx_i);
    lane_o      = half_i & lin[0];
    if (ctx_i)       mem_addr_o = ctx_word;
    else if (half_i) mem_addr_o = lin >> 1;
    else             mem_addr_o = lin;
    host_addr_o = buf_i + (HOST_AW'(idx_i) << 2);
  end
endmodule

// File: rtl/ctx_cmd_engine.sv
module ctx_cmd_engine import ctx_pkg::*; #(
  parameter int              HOST_AW   = 32,
  parameter int              DATA_W    = 32,
  parameter int              MEM_AW    = 14,
  parameter int              CNT_W     = 16,
  parameter int              CH_W      = 5,
  parameter logic [MEM_AW-1:0] CTX_BASE = 14'h800,
  parameter int              CTX_WORDS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [7:0]         cmd_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [7:0]         status_i,
  input  logic [HOST_AW-1:0] buf_addr_i,
  input  logic [MEM_AW-1:0]  ext_addr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [7:0]         status_o,
  output logic               hreq_valid_o,
  input  logic               hreq_ready_i,
  output logic               hreq_we_o,
  output logic [HOST_AW-1:0] hreq_addr_o,
  output logic [DATA_W-1:0]  hreq_wdata_o,
  input  logic [DATA_W-1:0]  hrsp_rdata_i,
  input  logic               hreq_err_i,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  output logic [1:0]         mem_be_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  localparam int HALF_W = DATA_W / 2;

  state_e             state_q;
  logic [7:0]         cmd_q, stat_q;
  logic [CNT_W-1:0]   cnt_q, idx_q;
  logic [HOST_AW-1:0] buf_q;
  logic [MEM_AW-1:0]  ext_q;
  logic               done_q;

  logic               run, fire, last, to_mem, half, ctx, lane;
  op_e                op;
  logic [CH_W-1:0]    ch;
  logic [CNT_W-1:0]   beats;
  logic [7:0]         cmd_sel;
  logic [CNT_W-1:0]   cnt_sel;
  logic [HALF_W-1:0]  rd_half;

  assign run     = (state_q == ST_RUN);
  assign cmd_sel = run ? cmd_q : cmd_i;
  assign cnt_sel = run ? cnt_q : count_i;

  ctx_decode #(.CNT_W(CNT_W), .CH_W(CH_W), .CTX_WORDS(CTX_WORDS)) u_dec (
    .cmd_i(cmd_sel), .count_i(cnt_sel), .op_o(op), .to_mem_o(to_mem),
    .half_o(half), .ctx_o(ctx), .ch_o(ch), .beats_o(beats)
  );

  ctx_addr_gen #(
    .HOST_AW(HOST_AW), .MEM_AW(MEM_AW), .CNT_W(CNT_W), .CH_W(CH_W),
    .CTX_BASE(CTX_BASE), .CTX_WORDS(CTX_WORDS)
  ) u_agen (
    .ctx_i(ctx), .half_i(half), .ch_i(ch), .ext_i(ext_q), .buf_i(buf_q),
    .idx_i(idx_q), .mem_addr_o(mem_addr_o), .lane_o(lane),
    .host_addr_o(hreq_addr_o)
  );

  assign fire = run & hreq_ready_i;
  assign last = (idx_q == beats - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cmd_q    <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      buf_q    <= '0;
      ext_q    <= '0;
      stat_q   <= '0;
      done_q   <= 1'b0;
      status_o <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (start_i) begin
          cmd_q  <= cmd_i;
          cnt_q  <= count_i;
          buf_q  <= buf_addr_i;
          ext_q  <= ext_addr_i;
          stat_q <= status_i;
          idx_q  <= '0;
          if (op == OP_BAD) begin
            done_q   <= 1'b1;
            status_o <= (status_i & ~STAT_OWN) | STAT_ERR;
          end else if (beats == '0) begin
            done_q   <= 1'b1;
            status_o <= status_i & ~(STAT_OWN | STAT_ERR);
          end else begin
            state_q <= ST_RUN;
          end
        end
      end else if (fire) begin
        if (hreq_err_i) begin
          state_q  <= ST_IDLE;
          done_q   <= 1'b1;
          status_o <= (stat_q & ~STAT_OWN) | STAT_ERR;
        end else if (last) begin
          state_q  <= ST_IDLE;
          done_q   <= 1'b1;
          status_o <= stat_q & ~(STAT_OWN | STAT_ERR);
        end else begin
          idx_q <= idx_q + CNT_W'(1);
        end
      end
    end
  end

  assign busy_o       = run;
  assign done_o       = done_q;
  assign hreq_valid_o = run;
  assign hreq_we_o    = ~to_mem;
  assign rd_half      = lane ? mem_rdata_i[DATA_W-1:HALF_W] : mem_rdata_i[HALF_W-1:0];
  assign hreq_wdata_o = half ? DATA_W'(rd_half) : mem_rdata_i;
  assign mem_re_o     = run & ~to_mem;
  assign mem_we_o     = fire & to_mem & ~hreq_err_i;
  assign mem_be_o     = half ? (lane ? 2'b10 : 2'b01) : 2'b11;
  assign mem_wdata_o  = half ? {2{hrsp_rdata_i[HALF_W-1:0]}} : hrsp_rdata_i;
endmodule

// File: rtl/ctx_cmd_engine_chk.sv
module ctx_cmd_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic [7:0]  status_o,
  input logic        hreq_valid_o,
  input logic        hreq_ready_i,
  input logic        hreq_err_i,
  input logic [31:0] hreq_addr_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic [1:0]  mem_be_o
);
  p_valid_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_valid_o && !hreq_ready_i |=> hreq_valid_o && $stable(hreq_addr_o));

  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o && !mem_re_o && !hreq_valid_o);

  p_fault_nowrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_valid_o && hreq_ready_i && hreq_err_i |-> !mem_we_o);

  p_own_cleared_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !status_o[0]);

  p_lane_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_be_o != 2'b00);
endmodule

bind ctx_cmd_engine ctx_cmd_engine_chk u_chk (.*);

// File: tb/ctx_cmd_engine_test.sv
`timescale 1ns/1ps
module ctx_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd = '0, stat_in = '0;
  logic [15:0] count = '0;
  logic [31:0] buf_addr = '0;
  logic [13:0] ext_addr = '0;
  logic        busy, done, hv, hready = 1'b0, hwe, herr, mwe, mre;
  logic [7:0]  stat_out;
  logic [31:0] haddr, hwdata, hrdata, mwdata, mrdata;
  logic [13:0] maddr;
  logic [1:0]  mbe;

  logic [31:0] ram [4096];
  logic [31:0] host [256];
  logic [31:0] exp_ram [4096];
  logic [31:0] exp_host [256];
  int          beat_cnt, err_at;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  ctx_cmd_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .count_i(count),
    .status_i(stat_in), .buf_addr_i(buf_addr), .ext_addr_i(ext_addr),
    .busy_o(busy), .done_o(done), .status_o(stat_out),
    .hreq_valid_o(hv), .hreq_ready_i(hready), .hreq_we_o(hwe),
    .hreq_addr_o(haddr), .hreq_wdata_o(hwdata), .hrsp_rdata_i(hrdata),
    .hreq_err_i(herr), .mem_we_o(mwe), .mem_re_o(mre), .mem_addr_o(maddr),
    .mem_be_o(mbe), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  assign hrdata = host[haddr[9:2]];
  assign mrdata = ram[maddr[11:0]];
  assign herr   = (beat_cnt == err_at);

  always @(posedge clk) begin
    if (hv && hready) begin
      beat_cnt <= beat_cnt + 1;
      if (hwe && !herr) host[haddr[9:2]] <= hwdata;
    end
    if (mwe) begin
      if (mbe[0]) ram[maddr[11:0]][15:0]  <= mwdata[15:0];
      if (mbe[1]) ram[maddr[11:0]][31:16] <= mwdata[31:16];
    end
  end

  always @(negedge clk) hready <= ($urandom % 4) != 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic int n_beats(input logic [7:0] c, input logic [15:0] n);
    if (c[2:0] == 3'b111 || c[2:0] == 3'b011) return 32;
    if (c == 8'h01 || c == 8'h02 || c == 8'h04 || c == 8'h08) return int'(n);
    return 0;
  endfunction

  function automatic bit is_bad(input logic [7:0] c);
    return !(c[2:0] == 3'b111 || c[2:0] == 3'b011 ||
             c == 8'h01 || c == 8'h02 || c == 8'h04 || c == 8'h08);
  endfunction

  // apply effect of beats 0..k-1 to the expected images
  task automatic model(input logic [7:0] c, input int k, input int bidx,
                       input logic [13:0] ext);
    for (int i = 0; i < k; i++) begin
      int          w;
      logic [13:0] h;
      h = ext + 14'(i);
      if (c[2:0] == 3'b111) exp_ram[12'h800 + 32 * c[7:3] + i] = exp_host[bidx + i];
      else if (c[2:0] == 3'b011) exp_host[bidx + i] = exp_ram[12'h800 + 32 * c[7:3] + i];
      else if (c == 8'h01) exp_ram[h[11:0]] = exp_host[bidx + i];
      else if (c == 8'h02) exp_host[bidx + i] = exp_ram[h[11:0]];
      else if (c == 8'h04) begin
        w = int'(h[12:1]);
        if (h[0]) exp_ram[w][31:16] = exp_host[bidx + i][15:0];
        else      exp_ram[w][15:0]  = exp_host[bidx + i][15:0];
      end else if (c == 8'h08) begin
        w = int'(h[12:1]);
        exp_host[bidx + i] = {16'h0, h[0] ? exp_ram[w][31:16] : exp_ram[w][15:0]};
      end
    end
  endtask

  task automatic run_cmd(input logic [7:0] c, input logic [15:0] n,
                         input logic [13:0] ext, input int bidx,
                         input logic [7:0] st, input int fault_at,
                         input bit poke, input string req);
    int          nb, k, guard, bad_ram, bad_host;
    bit          failed;
    logic [7:0]  exp_st;
    nb = n_beats(c, n);
    failed = is_bad(c) || (fault_at >= 0 && fault_at < nb);
    k = (fault_at >= 0 && fault_at < nb) ? fault_at : nb;
    for (int i = 0; i < 4096; i++) exp_ram[i] = ram[i];
    for (int i = 0; i < 256; i++) exp_host[i] = host[i];
    model(c, k, bidx, ext);
    @(negedge clk);
    beat_cnt = 0;
    err_at   = fault_at;
    cmd = c; count = n; ext_addr = ext; buf_addr = 32'(bidx * 4); stat_in = st;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; cmd = 8'h10; count = 16'd3;
      @(negedge clk);
      start = 1'b0; cmd = c;
    end
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    exp_st = failed ? ((st & 8'hEE) | 8'h10) : (st & 8'hEE);
    check(done && !busy, "R13", "done with busy low", {busy, done}, 32'h1);
    check(stat_out == exp_st, failed ? "R9/R10" : "R10", "status", stat_out, exp_st);
    check(beat_cnt == (failed && !is_bad(c) ? k + 1 : nb), "R11", "beat count",
          beat_cnt, failed && !is_bad(c) ? k + 1 : nb);
    bad_ram = -1; bad_host = -1;
    for (int i = 0; i < 4096; i++) if (bad_ram < 0 && ram[i] !== exp_ram[i]) bad_ram = i;
    for (int i = 0; i < 256; i++) if (bad_host < 0 && host[i] !== exp_host[i]) bad_host = i;
    check(bad_ram < 0, req, "internal memory image",
          bad_ram < 0 ? 0 : ram[bad_ram], bad_ram < 0 ? 0 : exp_ram[bad_ram]);
    check(bad_host < 0, req, "host buffer image",
          bad_host < 0 ? 0 : host[bad_host], bad_host < 0 ? 0 : exp_host[bad_host]);
    @(negedge clk);
    check(!done && !busy, poke ? "R12" : "R13", "idle after done", {busy, done}, 0);
    err_at = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] cmds [8];
    void'($urandom(32'd1234));
    err_at = -1; beat_cnt = 0;
    for (int i = 0; i < 4096; i++) ram[i] = $urandom;
    for (int i = 0; i < 256; i++) host[i] = $urandom;
    repeat (3) @(negedge clk);
    check(!busy && !done && !hv && stat_out == 0, "R13", "reset state",
          {busy, done, hv, stat_out}, 0);
    rst_n = 1'b1;
    // directed
    run_cmd(8'h3F, 16'd5, 14'h0, 10, 8'h09, -1, 0, "R1");   // ctx restore ch7
    run_cmd(8'hFB, 16'd0, 14'h0, 60, 8'h01, -1, 0, "R2");   // ctx save ch31
    run_cmd(8'h01, 16'd9, 14'h123, 100, 8'h01, -1, 0, "R3");
    run_cmd(8'h02, 16'd7, 14'h200, 120, 8'h11, -1, 0, "R4");
    run_cmd(8'h04, 16'd6, 14'h301, 130, 8'h01, -1, 0, "R5");
    run_cmd(8'h08, 16'd5, 14'h401, 140, 8'h01, -1, 0, "R6");
    run_cmd(8'h01, 16'd0, 14'h10, 0, 8'h01, -1, 0, "R7");
    run_cmd(8'h10, 16'd4, 14'h10, 0, 8'h01, -1, 0, "R8");
    run_cmd(8'h05, 16'd4, 14'h10, 0, 8'h00, -1, 0, "R8");
    run_cmd(8'h01, 16'd6, 14'h500, 20, 8'h01, 5, 0, "R9");  // fault on last beat
    run_cmd(8'h0F, 16'd1, 14'h0, 30, 8'h01, 31, 0, "R9");   // ctx last beat fault
    run_cmd(8'h08, 16'd6, 14'h51, 40, 8'h01, 0, 0, "R9");   // fault first beat
    run_cmd(8'h01, 16'd10, 14'h600, 70, 8'h01, -1, 1, "R12");
    // random
    cmds = '{8'h07, 8'h03, 8'h01, 8'h02, 8'h04, 8'h08, 8'h0C, 8'h01};
    for (int t = 0; t < 30; t++) begin
      logic [7:0] c;
      c = cmds[$urandom % 8];
      if (c[2:0] == 3'b111 || c[2:0] == 3'b011) c[7:3] = 5'($urandom);
      run_cmd(c, 16'($urandom % 20), 14'($urandom % 14'h700), int'($urandom % 200),
              8'($urandom) | 8'h01, ($urandom % 4 == 0) ? int'($urandom % 20) : -1,
              0, "R3/R4/R5/R6");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule